// File: doc/BRIEF.md
# PDM Microphone Clock and Capture Front End

This block drives the clock of one or two external pulse-density-modulated microphones and gathers their one-bit data streams. It runs entirely from a 24 MHz system clock. A counter divides that clock down to 1.5 MHz, 2.0 MHz or 3.0 MHz with equal high and low phases. Every data pin is sampled in the system-clock cycle just before a microphone clock transition, so no second clock domain is needed.

Two wiring options are supported. In uniplex mode each microphone has its own data pin and both pins are sampled at the rising transition. In multiplex mode both microphones share the first data pin and are told apart by clock phase: left is taken before the rising transition and right before the falling one. In both modes the block emits one left/right bit pair per microphone clock period, with a one-cycle strobe on each channel. A downstream decimator therefore sees a single stereo sample stream. A clock-enable input stops the microphone clock for power saving.

Top module: `pdm_mic_frontend`

## Requirements
- R1: While `rst_ni` is low, `mic_clk_o`, `left_vld_o` and `right_vld_o` are all 0 after the next clock edge.
- R2: Rate code `rate_sel_i` 0 divides by DIV_SLOW (16), code 1 by DIV_MID (12), code 2 by DIV_FAST (8), and code 3 behaves like code 0. Each high and each low phase lasts exactly half the divide ratio in system cycles (8, 6 or 4).
- R3: Rate code and mode are taken only at a falling transition of `mic_clk_o`, or on any cycle while the clock is disabled. Within every full period the low phase and the following high phase are equally long, and no phase is shorter than DIV_FAST/2 cycles unless it is cut short by the enable.
- R4: With `mux_mode_i` = 0 (uniplex), `left_bit_o` carries the level of `pdm_pin0_i` and `right_bit_o` the level of `pdm_pin1_i` in the cycle before `mic_clk_o` rises. Both strobes pulse for one cycle in the first cycle that `mic_clk_o` is high.
- R5: With `mux_mode_i` = 1 (multiplex), `left_bit_o` carries the level of `pdm_pin0_i` in the cycle before the rise, and `right_bit_o` its level in the cycle before the fall. Both strobes pulse in the first cycle that `mic_clk_o` is low again. `pdm_pin1_i` has no effect.
- R6: `left_vld_o` and `right_vld_o` are always asserted together, exactly once per microphone clock period, and no captured pair is dropped or repeated.
- R7: After a cycle with `mic_clk_en_i` = 0, `mic_clk_o` is 0 and no strobe is asserted, whatever the data pins do. A restart begins with a low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 24 MHz system clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| mic_clk_en_i | input | 1 | Microphone clock enable; 0 stops the clock and capture |
| rate_sel_i | input | 2 | Rate code: 0 and 3 = /16, 1 = /12, 2 = /8 |
| mux_mode_i | input | 1 | 0 = one microphone per pin, 1 = two microphones on pin 0 |
| pdm_pin0_i | input | 1 | First microphone data pin |
| pdm_pin1_i | input | 1 | Second microphone data pin (uniplex only) |
| mic_clk_o | output | 1 | Clock to the microphones |
| left_bit_o | output | 1 | Captured left bit |
| left_vld_o | output | 1 | One-cycle strobe for left_bit_o |
| right_bit_o | output | 1 | Captured right bit |
| right_vld_o | output | 1 | One-cycle strobe for right_bit_o |

## Verification
The assertions assume that the data pins and configuration inputs are synchronous to `clk_i`. They also assume that a mode change is not followed by a strobe from the old mode, except at the falling boundary where the previous mode is still in force. The stimulus obeys this by driving every input one nanosecond after a rising system edge. The microphone model changes its data only just after a microphone clock transition, so each bit is stable through the capturing cycle. The mode is changed only while the clock is disabled. The rate is changed both while disabled and in the middle of a running period.

// File: rtl/pdm_mic_pkg.sv
// Shared types for the PDM microphone front end.
// Assumes all divide ratios are even, so that both phases are equal.
package pdm_mic_pkg;

    typedef enum logic [1:0] {
        RATE_SLOW     = 2'd0,
        RATE_MID      = 2'd1,
        RATE_FAST     = 2'd2,
        RATE_SLOW_ALT = 2'd3
    } mic_rate_e;

    typedef enum logic {
        MODE_UNIPLEX   = 1'b0,
        MODE_MULTIPLEX = 1'b1
    } mic_mode_e;

    typedef struct packed {
        mic_mode_e mode;
        mic_rate_e rate;
    } mic_cfg_t;

    // Number of system cycles in one half of a microphone clock period.
    function automatic int unsigned half_div(input mic_rate_e r,
                                             input int unsigned d_slow,
                                             input int unsigned d_mid,
                                             input int unsigned d_fast);
        case (r)
            RATE_MID:  return d_mid / 2;
            RATE_FAST: return d_fast / 2;
            default:   return d_slow / 2;
        endcase
    endfunction

endpackage

// File: rtl/pdm_clk_div.sv
// Microphone clock divider.
// Produces a 50% duty clock from clk_i. It flags the cycle just before each
// rising or falling transition, and latches the configuration at the falling
// boundary or while stopped.
// Assumes DIV_SLOW >= DIV_MID >= DIV_FAST, all even and at least 4.
module pdm_clk_div
    import pdm_mic_pkg::*;
#(
    parameter int unsigned DIV_SLOW = 16,
    parameter int unsigned DIV_MID  = 12,
    parameter int unsigned DIV_FAST = 8,
    localparam int unsigned CNT_W   = $clog2(DIV_SLOW / 2)
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     run_i,
    input  mic_cfg_t cfg_i,
    output logic     mic_clk_o,
    output logic     rise_o,
    output logic     fall_o,
    output mic_cfg_t cfg_q_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;
    logic             mic_clk_q;
    logic             phase_end;
    mic_cfg_t         cfg_q;

    // Terminal count of the current half period, taken from the latched rate.
    assign last_cnt  = CNT_W'(half_div(cfg_q.rate, DIV_SLOW, DIV_MID, DIV_FAST) - 1);
    assign phase_end = run_i && (cnt_q == last_cnt);
    assign rise_o    = phase_end && !mic_clk_q;
    assign fall_o    = phase_end &&  mic_clk_q;

    // Half-period counter and output clock; a stop forces the clock low.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !run_i) begin
            cnt_q     <= '0;
            mic_clk_q <= 1'b0;
        end else if (phase_end) begin
            cnt_q     <= '0;
            mic_clk_q <= !mic_clk_q;
        end else begin
            cnt_q     <= cnt_q + 1'b1;
        end
    end

    // Configuration latch: follows the inputs while stopped, else only at a fall.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_q <= '{mode: MODE_UNIPLEX, rate: RATE_SLOW};
        end else if (!run_i || fall_o) begin
            cfg_q <= cfg_i;
        end
    end

    assign mic_clk_o = mic_clk_q;
    assign cfg_q_o   = cfg_q;

endmodule

// File: rtl/pdm_capture.sv
// Data capture and stereo pairing.
// Samples the data pins on the cycle flagged by the divider and presents one
// left/right pair with per-channel strobes.
// Assumes rise_i and fall_i are never high together.
module pdm_capture #(
    parameter int unsigned NUM_CH = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              mux_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              pin0_i,
    input  logic              pin1_i,
    output logic [NUM_CH-1:0] bit_o,
    output logic [NUM_CH-1:0] vld_o
);

    logic held_left_q;
    logic take;

    // Uniplex pairs at the rise; multiplex pairs once the right bit arrives.
    assign take = mux_i ? fall_i : rise_i;

    // Holds the multiplexed left bit until its right partner is sampled.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            held_left_q <= 1'b0;
        end else if (mux_i && rise_i) begin
            held_left_q <= pin0_i;
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        logic uni_src;
        logic mux_src;
        logic bit_q;
        logic vld_q;

        assign uni_src = (ch == 0) ? pin0_i : pin1_i;
        assign mux_src = (ch == 0) ? held_left_q : pin0_i;

        // Per-channel output bit and one-cycle strobe.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                bit_q <= 1'b0;
                vld_q <= 1'b0;
            end else begin
                vld_q <= take;
                if (take) begin
                    bit_q <= mux_i ? mux_src : uni_src;
                end
            end
        end

        assign bit_o[ch] = bit_q;
        assign vld_o[ch] = vld_q;
    end

endmodule

// File: rtl/pdm_mic_frontend.sv
// PDM microphone front end top level.
// Joins the clock divider and the capture stage.
// Assumes all inputs are synchronous to clk_i, which runs at 24 MHz.
module pdm_mic_frontend
    import pdm_mic_pkg::*;
#(
    parameter int unsigned DIV_SLOW = 16,
    parameter int unsigned DIV_MID  = 12,
    parameter int unsigned DIV_FAST = 8
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       mic_clk_en_i,
    input  logic [1:0] rate_sel_i,
    input  logic       mux_mode_i,
    input  logic       pdm_pin0_i,
    input  logic       pdm_pin1_i,
    output logic       mic_clk_o,
    output logic       left_bit_o,
    output logic       left_vld_o,
    output logic       right_bit_o,
    output logic       right_vld_o
);

    localparam int unsigned NUM_CH = 2;

    mic_cfg_t          cfg_in;
    mic_cfg_t          cfg_q;
    logic              cur_mux;
    logic [1:0]        cur_rate;
    logic              rise;
    logic              fall;
    logic [NUM_CH-1:0] ch_bit;
    logic [NUM_CH-1:0] ch_vld;

    assign cfg_in.mode = mic_mode_e'(mux_mode_i);
    assign cfg_in.rate = mic_rate_e'(rate_sel_i);
    assign cur_mux     = (cfg_q.mode == MODE_MULTIPLEX);
    assign cur_rate    = cfg_q.rate;

    pdm_clk_div #(
        .DIV_SLOW (DIV_SLOW),
        .DIV_MID  (DIV_MID),
        .DIV_FAST (DIV_FAST)
    ) div_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (mic_clk_en_i),
        .cfg_i     (cfg_in),
        .mic_clk_o (mic_clk_o),
        .rise_o    (rise),
        .fall_o    (fall),
        .cfg_q_o   (cfg_q)
    );

    pdm_capture #(
        .NUM_CH (NUM_CH)
    ) cap_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .mux_i  (cur_mux),
        .rise_i (rise),
        .fall_i (fall),
        .pin0_i (pdm_pin0_i),
        .pin1_i (pdm_pin1_i),
        .bit_o  (ch_bit),
        .vld_o  (ch_vld)
    );

    assign left_bit_o  = ch_bit[0];
    assign right_bit_o = ch_bit[1];
    assign left_vld_o  = ch_vld[0];
    assign right_vld_o = ch_vld[1];

endmodule

// File: rtl/pdm_mic_frontend_chk.sv
// Property checker for pdm_mic_frontend, attached with bind.
// Assumes it sees the top-level ports plus the latched mode and rate.
module pdm_mic_frontend_chk
    import pdm_mic_pkg::*;
#(
    parameter int unsigned DIV_SLOW = 16,
    parameter int unsigned DIV_MID  = 12,
    parameter int unsigned DIV_FAST = 8
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       mic_clk_en_i,
    input logic       mic_clk_o,
    input logic       left_vld_o,
    input logic       right_vld_o,
    input logic       cur_mux,
    input logic [1:0] cur_rate
);

    localparam logic [7:0] MIN_HALF = 8'(DIV_FAST / 2);

    logic [7:0] phase_cnt;
    logic       clk_prev;
    logic       in_reset_q;

    // Cycles since the last microphone clock transition, saturating.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            phase_cnt <= '0;
            clk_prev  <= 1'b0;
        end else begin
            clk_prev <= mic_clk_o;
            if (mic_clk_o != clk_prev) begin
                phase_cnt <= 8'd1;
            end else if (phase_cnt != 8'hFF) begin
                phase_cnt <= phase_cnt + 8'd1;
            end
        end
    end

    // Remembers that the previous edge was taken in reset.
    always_ff @(posedge clk_i) begin
        in_reset_q <= !rst_ni;
    end

    // Reset state check, R1.
    always @(posedge clk_i) begin
        if (in_reset_q) begin
            assert_reset_state_R1: assert (!mic_clk_o && !left_vld_o && !right_vld_o)
                else $error("reset state violated");
        end
    end

    assert_quiet_when_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mic_clk_en_i |=> (!mic_clk_o && !left_vld_o && !right_vld_o));

    assert_uniplex_on_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (left_vld_o && !$past(cur_mux)) |-> (mic_clk_o && !$past(mic_clk_o)));

    assert_multiplex_on_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (left_vld_o && $past(cur_mux)) |-> (!mic_clk_o && $past(mic_clk_o)));

    assert_no_runt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((mic_clk_o != $past(mic_clk_o)) && $past(mic_clk_en_i)) |-> (phase_cnt >= MIN_HALF));

    assert_high_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mic_clk_o && $past(mic_clk_o) && $past(mic_clk_en_i)) |->
        (phase_cnt == 8'(half_div(mic_rate_e'($past(cur_rate)), DIV_SLOW, DIV_MID, DIV_FAST))));

    assert_pair_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (left_vld_o || right_vld_o) |-> (left_vld_o && right_vld_o));

endmodule

bind pdm_mic_frontend pdm_mic_frontend_chk #(
    .DIV_SLOW (DIV_SLOW),
    .DIV_MID  (DIV_MID),
    .DIV_FAST (DIV_FAST)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mic_clk_en_i (mic_clk_en_i),
    .mic_clk_o    (mic_clk_o),
    .left_vld_o   (left_vld_o),
    .right_vld_o  (right_vld_o),
    .cur_mux      (cur_mux),
    .cur_rate     (cur_rate)
);

// File: tb/pdm_mic_frontend_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: a microphone model drives the pins and queues the pairs
// it expects; a monitor pops and compares them on every strobe.
module pdm_mic_frontend_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic       mux_mode = 1'b0;
    logic       pin0 = 1'b0;
    logic       pin1 = 1'b0;
    logic       mic_clk, l_bit, l_vld, r_bit, r_vld;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    logic       mode_q = 1'b0;
    logic       en_seen;
    logic [1:0] rate_seen;
    logic       l_pend, r_pend;
    logic [1:0] exp_q [$];

    always #2.5 clk = ~clk;

    pdm_mic_frontend dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .mic_clk_en_i (clk_en),
        .rate_sel_i   (rate_sel),
        .mux_mode_i   (mux_mode),
        .pdm_pin0_i   (pin0),
        .pdm_pin1_i   (pin1),
        .mic_clk_o    (mic_clk),
        .left_bit_o   (l_bit),
        .left_vld_o   (l_vld),
        .right_bit_o  (r_bit),
        .right_vld_o  (r_vld)
    );

    function automatic int half_of(input logic [1:0] code);
        case (code)
            2'd1:    return 6;
            2'd2:    return 4;
            default: return 8;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Input values as seen by the design at each rising edge.
    always @(posedge clk) begin
        en_seen   <= clk_en;
        rate_seen <= rate_sel;
    end

    // Put fresh bits on the pins for a new low phase.
    task automatic load_low_phase();
        l_pend = 1'($urandom % 2);
        r_pend = 1'($urandom % 2);
        pin0   = l_pend;
        pin1   = mode_q ? 1'($urandom % 2) : r_pend;
    endtask

    // Microphone model: changes data just after each clock transition.
    always @(mic_clk) begin
        #1;
        if (mic_clk === 1'b1) begin
            if (mode_q) begin
                pin0 = r_pend;
                pin1 = 1'($urandom % 2);
            end else if (en_seen === 1'b1) begin
                exp_q.push_back({l_pend, r_pend});
            end
        end else if (mic_clk === 1'b0 && en_seen === 1'b1) begin
            if (mode_q) exp_q.push_back({l_pend, r_pend});
            load_low_phase();
        end
    end

    // Monitor: strobes, scoreboard, phase lengths, quiet state.
    logic prev_mic = 1'b0;
    int   lo_len = 0, hi_len = 0, per_rate = 0;
    bit   have_low = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            check(!mic_clk && !l_vld && !r_vld, "R1", "outputs in reset",
                  int'({mic_clk, l_vld, r_vld}), 0);
        end else begin
            if (l_vld || r_vld) begin
                logic [1:0] e;
                check(l_vld && r_vld, "R6", "strobes together", int'({l_vld, r_vld}), 3);
                if (mode_q)
                    check(!mic_clk && prev_mic, "R5", "strobe at fall",
                          int'({prev_mic, mic_clk}), 2);
                else
                    check(mic_clk && !prev_mic, "R4", "strobe at rise",
                          int'({prev_mic, mic_clk}), 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected pair", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check({l_bit, r_bit} == e, mode_q ? "R5" : "R4", "captured pair",
                          int'({l_bit, r_bit}), int'(e));
                end
            end
            if (en_seen !== 1'b1) begin
                check(!mic_clk && !l_vld && !r_vld, "R7", "quiet while off",
                      int'({mic_clk, l_vld, r_vld}), 0);
                have_low = 1'b0;
                lo_len   = 0;
                hi_len   = 0;
            end else if (mic_clk && !prev_mic) begin
                hi_len = 1;
            end else if (mic_clk && prev_mic) begin
                hi_len++;
            end else if (!mic_clk && prev_mic) begin
                if (have_low) begin
                    check(hi_len == lo_len, "R3", "high equals low in period", hi_len, lo_len);
                    check(hi_len == half_of(2'(per_rate)), "R2", "half period length",
                          hi_len, half_of(2'(per_rate)));
                end
                per_rate = int'(rate_seen);
                have_low = 1'b1;
                lo_len   = 1;
            end else begin
                lo_len++;
            end
        end
        prev_mic = mic_clk;
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic start_run(input logic mode, input logic [1:0] rate);
        cycles(1);
        mode_q   = mode;
        mux_mode = mode;
        rate_sel = rate;
        load_low_phase();
        cycles(2);
        clk_en = 1'b1;
    endtask

    // Stop the clock and wiggle the pins, which must have no effect (R7).
    task automatic stop_run();
        cycles(1);
        clk_en = 1'b0;
        for (int i = 0; i < 30; i++) begin
            cycles(1);
            pin0 = 1'($urandom % 2);
            pin1 = 1'($urandom % 2);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (60000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        cycles(8);
        rst_n = 1'b1;
        // R4: uniplex at each rate (R2 via monitor)
        start_run(1'b0, 2'd0);
        cycles(300);
        // R3: rate change in mid period while running
        @(posedge mic_clk);
        cycles(2);
        rate_sel = 2'd2;
        cycles(200);
        rate_sel = 2'd1;
        cycles(200);
        stop_run();
        // R5: multiplex, code 3 behaves like code 0
        start_run(1'b1, 2'd3);
        cycles(300);
        rate_sel = 2'd2;
        cycles(200);
        // R7: stop while the clock is high
        @(posedge mic_clk);
        cycles(1);
        stop_run();
        start_run(1'b1, 2'd1);
        cycles(300);
        stop_run();
        // R4 again at the fast rate
        start_run(1'b0, 2'd2);
        cycles(200);
        stop_run();
        // R1: reset in mid run
        start_run(1'b0, 2'd1);
        cycles(40);
        rst_n = 1'b0;
        clk_en = 1'b0;
        cycles(4);
        rst_n = 1'b1;
        exp_q.delete();
        cycles(10);
        check(exp_q.size() == 0, "R6", "leftover expected pairs", exp_q.size(), 0);
        finish_up();
    end

endmodule